// File: doc/BRIEF.md
# Interrupt request conditioner and vector arbiter

This block sits between a small processor core and its interrupt sources. It accepts three kinds of request:

- an active-low non-maskable pin;
- an active-low maskable pin, which can be set at run time to follow the pin level or to capture a falling edge;
- a vector of peripheral event pulses, each held in a sticky flag.

Both pins pass through a two-stage synchronizer. The block then combines every live request under a global mask and drives a single pending line to the core.

When the core raises its acknowledge strobe, the block registers the index of the highest-priority live source. If nothing is live at that moment, it registers the trap index instead. A latched edge on the maskable pin clears itself when its vector is handed out. Peripheral flags clear only through their own clear inputs.

Top module: `intc_front`

## Requirements
- R1: After reset, `pending` is 0 and `vecIdx` is 0 (the trap index).
- R2: A low level on `nmiPinN` asserts `pending` whatever `globalMask` is. An acknowledge then returns index 1. Raising the pin removes the request, because no latch is kept for it.
- R3: With `irqEdgeMode`=0, a low `irqPinN` produces a request that follows the synchronized pin level. An acknowledge returns index 2 and does not remove the request. Raising the pin removes it.
- R4: With `irqEdgeMode`=1, a high sample followed by at least HOLD_CYCLES consecutive low samples sets an edge latch. The request stays after the pin rises. A low pulse shorter than HOLD_CYCLES cycles sets nothing.
- R5: The edge latch clears on an acknowledge that returns index 2. If a new qualifying edge lands in that same cycle, the latch stays set.
- R6: A pulse on `flagSet[k]` sets flag k, and the flag stays set until `flagClr[k]` is pulsed. An acknowledge never clears a flag. The index for flag k is 3+k. When set and clear arrive in the same cycle, the flag ends up set.
- R7: While `globalMask` is 1, the maskable pin and all flags are hidden from `pending` and from arbitration. An edge latched while masked is still pending once the mask drops.
- R8: The priority order, highest first, is: the non-maskable pin, then the maskable pin, then flags from bit 0 upward.
- R9: An acknowledge taken while no source is live returns index 0.
- R10: `vecIdx` changes only in the cycle after an acknowledge and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nmiPinN | input | 1 | Non-maskable request pin, active low |
| irqPinN | input | 1 | Maskable request pin, active low |
| irqEdgeMode | input | 1 | 1 = falling-edge capture, 0 = level |
| globalMask | input | 1 | 1 hides the maskable pin and the flags |
| flagSet | input | NUM_FLAGS | Per-flag set pulses |
| flagClr | input | NUM_FLAGS | Per-flag clear pulses |
| ack | input | 1 | Core starts servicing |
| pending | output | 1 | Some unmasked source is live |
| vecIdx | output | VEC_W | Registered vector index |

## Verification
Two functions can fall in the same cycle: the acknowledge that clears the edge latch, and the qualification of a fresh falling edge. The bench provokes this by driving the pin low exactly three cycles before it raises `ack`. That places the final hold sample on the acknowledge edge.

The outcome is judged at the ports. The returned index must be 2, and `pending` must still be high afterwards, because the new edge outranks the clear. The same set-over-clear rule is checked for a flag that receives its set and clear pulses together.

// File: rtl/intc_front_pkg.sv
package intc_front_pkg;
  localparam int unsigned VEC_TRAP  = 0;
  localparam int unsigned VEC_NMI   = 1;
  localparam int unsigned VEC_PIN   = 2;
  localparam int unsigned VEC_FLAG0 = 3;

  typedef struct packed {
    logic nmiLive;   // synchronized non-maskable pin is low
    logic pinLive;   // synchronized maskable pin is low
    logic edgeHit;   // qualified falling edge this cycle
  } ctlStrobes_t;
endpackage

// File: rtl/intc_front_ctl.sv
module intc_front_ctl
  import intc_front_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        nmiPinN,
  input  logic        irqPinN,
  output ctlStrobes_t strb
);
  localparam int unsigned CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_CYCLES - 1);

  logic [1:0]       nmiSync;
  logic [1:0]       irqSync;
  logic [CNT_W-1:0] lowCnt;
  logic             armed;
  logic             edgeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiSync <= 2'b11;
      irqSync <= 2'b11;
    end else begin
      nmiSync <= {nmiSync[0], nmiPinN};
      irqSync <= {irqSync[0], irqPinN};
    end
  end

  // A high sample arms the detector. A run of HOLD_CYCLES low samples fires it once.
  assign edgeHit = armed && !irqSync[1] && (lowCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      lowCnt <= '0;
    end else if (irqSync[1]) begin
      armed  <= 1'b1;
      lowCnt <= '0;
    end else if (armed) begin
      if (edgeHit) begin
        armed  <= 1'b0;
        lowCnt <= '0;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  assign strb.nmiLive = !nmiSync[1];
  assign strb.pinLive = !irqSync[1];
  assign strb.edgeHit = edgeHit;
endmodule

// File: rtl/intc_front_dp.sv
module intc_front_dp
  import intc_front_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned VEC_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic                 irqEdgeMode,
  input  logic                 globalMask,
  input  logic [NUM_FLAGS-1:0] flagSet,
  input  logic [NUM_FLAGS-1:0] flagClr,
  input  logic                 ack,
  output logic                 pending,
  output logic [VEC_W-1:0]     vecIdx
);
  logic                 edgeLatch;
  logic [NUM_FLAGS-1:0] flagReg;
  logic [NUM_FLAGS-1:0] flagReq;
  logic                 pinReq;
  logic                 maskedPin;
  logic [VEC_W-1:0]     winVec;
  logic                 winPin;

  // A new edge takes precedence over the clear from servicing.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                edgeLatch <= 1'b0;
    else if (!irqEdgeMode)    edgeLatch <= 1'b0;
    else if (strb.edgeHit)    edgeLatch <= 1'b1;
    else if (ack && winPin)   edgeLatch <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagReg <= '0;
    else       flagReg <= (flagReg & ~flagClr) | flagSet;
  end

  assign pinReq    = irqEdgeMode ? edgeLatch : strb.pinLive;
  assign maskedPin = pinReq && !globalMask;
  assign flagReq   = flagReg & {NUM_FLAGS{!globalMask}};

  always_comb begin
    winVec = VEC_W'(VEC_TRAP);
    winPin = 1'b0;
    for (int k = NUM_FLAGS - 1; k >= 0; k--) begin
      if (flagReq[k]) winVec = VEC_W'(VEC_FLAG0 + k);
    end
    if (maskedPin) begin
      winVec = VEC_W'(VEC_PIN);
      winPin = 1'b1;
    end
    if (strb.nmiLive) begin
      winVec = VEC_W'(VEC_NMI);
      winPin = 1'b0;
    end
  end

  assign pending = strb.nmiLive || maskedPin || (|flagReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    vecIdx <= VEC_W'(VEC_TRAP);
    else if (ack) vecIdx <= winVec;
  end
endmodule

// File: rtl/intc_front.sv
module intc_front
  import intc_front_pkg::*;
#(
  parameter int unsigned NUM_FLAGS   = 8,
  parameter int unsigned HOLD_CYCLES = 2,
  localparam int unsigned VEC_W      = $clog2(NUM_FLAGS + VEC_FLAG0)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nmiPinN,
  input  logic                 irqPinN,
  input  logic                 irqEdgeMode,
  input  logic                 globalMask,
  input  logic [NUM_FLAGS-1:0] flagSet,
  input  logic [NUM_FLAGS-1:0] flagClr,
  input  logic                 ack,
  output logic                 pending,
  output logic [VEC_W-1:0]     vecIdx
);
  ctlStrobes_t strb;

  intc_front_ctl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .nmiPinN (nmiPinN),
    .irqPinN (irqPinN),
    .strb    (strb)
  );

  intc_front_dp #(.NUM_FLAGS(NUM_FLAGS), .VEC_W(VEC_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .irqEdgeMode (irqEdgeMode),
    .globalMask  (globalMask),
    .flagSet     (flagSet),
    .flagClr     (flagClr),
    .ack         (ack),
    .pending     (pending),
    .vecIdx      (vecIdx)
  );
endmodule

// File: rtl/intc_front_chk.sv
module intc_front_chk #(
  parameter int unsigned VEC_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             nmiPinN,
  input logic             globalMask,
  input logic             ack,
  input logic             pending,
  input logic [VEC_W-1:0] vecIdx
);
  p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ack |=> $stable(vecIdx));

  p_trap_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !pending) |=> (vecIdx == '0));

  p_live_vec_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ack && pending) |=> (vecIdx != '0));

  p_nmi_unmasked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!nmiPinN && !$past(nmiPinN) && !$past(nmiPinN, 2)) |-> pending);

  p_nmi_vec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !nmiPinN && !$past(nmiPinN) && !$past(nmiPinN, 2)) |=> (vecIdx == VEC_W'(1)));

  p_mask_hides_r7: assert property (@(posedge clk) disable iff (!rstN)
    (globalMask && nmiPinN && $past(nmiPinN) && $past(nmiPinN, 2)) |-> !pending);
endmodule

bind intc_front intc_front_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .nmiPinN    (nmiPinN),
  .globalMask (globalMask),
  .ack        (ack),
  .pending    (pending),
  .vecIdx     (vecIdx)
);

// File: tb/intc_front_bench.sv
module intc_front_bench;
  localparam int unsigned NF = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          nmiPinN = 1'b1;
  logic          irqPinN = 1'b1;
  logic          irqEdgeMode = 1'b0;
  logic          globalMask = 1'b0;
  logic [NF-1:0] flagSet = '0;
  logic [NF-1:0] flagClr = '0;
  logic          ack = 1'b0;
  logic          pending;
  logic [3:0]    vecIdx;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  intc_front #(.NUM_FLAGS(NF), .HOLD_CYCLES(2)) u_intc_front (
    .clk(clk), .rstN(rstN), .nmiPinN(nmiPinN), .irqPinN(irqPinN),
    .irqEdgeMode(irqEdgeMode), .globalMask(globalMask),
    .flagSet(flagSet), .flagClr(flagClr), .ack(ack),
    .pending(pending), .vecIdx(vecIdx)
  );

  always #2 clk = ~clk;

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doAck();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic pulseFlags(input logic [NF-1:0] s, input logic [NF-1:0] c);
    flagSet = s;
    flagClr = c;
    tick(1);
    flagSet = '0;
    flagClr = '0;
  endtask

  task automatic t_reset();
    chk("R1 pending after reset", int'(pending), 0);
    chk("R1 vecIdx after reset", int'(vecIdx), 0);
  endtask

  task automatic t_nmi();
    globalMask = 1'b1;
    nmiPinN = 1'b0;
    tick(3);
    chk("R2 nmi pending while masked", int'(pending), 1);
    doAck();
    chk("R2 nmi vector", int'(vecIdx), 1);
    nmiPinN = 1'b1;
    tick(3);
    chk("R2 nmi released, no latch", int'(pending), 0);
    globalMask = 1'b0;
  endtask

  task automatic t_level();
    irqEdgeMode = 1'b0;
    irqPinN = 1'b0;
    tick(3);
    chk("R3 level pending", int'(pending), 1);
    doAck();
    chk("R3 level vector", int'(vecIdx), 2);
    chk("R3 level stays after ack", int'(pending), 1);
    irqPinN = 1'b1;
    tick(3);
    chk("R3 level released", int'(pending), 0);
    doAck();
    chk("R9 trap vector with nothing live", int'(vecIdx), 0);
  endtask

  task automatic t_edge();
    irqEdgeMode = 1'b1;
    tick(4);
    irqPinN = 1'b0;
    tick(2);
    irqPinN = 1'b1;
    tick(5);
    chk("R4 edge latched after release", int'(pending), 1);
    doAck();
    chk("R4 edge vector", int'(vecIdx), 2);
    chk("R5 edge latch cleared by ack", int'(pending), 0);
    irqPinN = 1'b0;
    tick(1);
    irqPinN = 1'b1;
    tick(6);
    chk("R4 short pulse ignored", int'(pending), 0);
  endtask

  task automatic t_mask_edge();
    globalMask = 1'b1;
    irqPinN = 1'b0;
    tick(3);
    irqPinN = 1'b1;
    tick(5);
    chk("R7 masked edge hidden", int'(pending), 0);
    doAck();
    chk("R9 trap while masked", int'(vecIdx), 0);
    globalMask = 1'b0;
    tick(1);
    chk("R7 masked edge kept", int'(pending), 1);
    doAck();
    chk("R7 kept edge vector", int'(vecIdx), 2);
    chk("R5 cleared after unmasked ack", int'(pending), 0);
  endtask

  task automatic t_same_cycle();
    irqEdgeMode = 1'b1;
    tick(4);
    irqPinN = 1'b0;
    tick(2);
    irqPinN = 1'b1;
    tick(5);
    chk("R4 first edge latched", int'(pending), 1);
    irqPinN = 1'b0;
    tick(3);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    chk("R5 vector on coincident ack", int'(vecIdx), 2);
    chk("R5 new edge wins over clear", int'(pending), 1);
    irqPinN = 1'b1;
    doAck();
    chk("R5 second edge cleared", int'(pending), 0);
    irqEdgeMode = 1'b0;
    tick(2);
  endtask

  task automatic t_flags();
    pulseFlags(8'b0010_0100, '0);
    tick(1);
    chk("R6 flags pending", int'(pending), 1);
    doAck();
    chk("R6 lowest flag vector", int'(vecIdx), 5);
    doAck();
    chk("R6 flag not cleared by ack", int'(vecIdx), 5);
    globalMask = 1'b1;
    tick(1);
    chk("R7 mask hides flags", int'(pending), 0);
    globalMask = 1'b0;
    pulseFlags('0, 8'b0000_0100);
    doAck();
    chk("R6 next flag after clear", int'(vecIdx), 8);
    pulseFlags('0, 8'b0010_0000);
    tick(1);
    chk("R6 all flags cleared", int'(pending), 0);
    pulseFlags(8'b1000_0000, 8'b1000_0000);
    tick(1);
    doAck();
    chk("R6 set wins over clear", int'(vecIdx), 10);
    pulseFlags('0, 8'b1000_0000);
    tick(1);
    chk("R6 flag seven cleared", int'(pending), 0);
  endtask

  task automatic t_priority();
    irqEdgeMode = 1'b0;
    pulseFlags(8'b0000_0001, '0);
    irqPinN = 1'b0;
    nmiPinN = 1'b0;
    tick(3);
    doAck();
    chk("R8 nmi first", int'(vecIdx), 1);
    nmiPinN = 1'b1;
    tick(3);
    doAck();
    chk("R8 pin before flags", int'(vecIdx), 2);
    irqPinN = 1'b1;
    tick(3);
    doAck();
    chk("R8 flag last", int'(vecIdx), 3);
    pulseFlags(8'b0000_0010, '0);
    tick(4);
    chk("R10 vector held without ack", int'(vecIdx), 3);
    pulseFlags('0, 8'b0000_0011);
    tick(1);
    chk("R10 idle after cleanup", int'(pending), 0);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    t_reset();
    t_nmi();
    t_level();
    t_edge();
    t_mask_edge();
    t_same_cycle();
    t_flags();
    t_priority();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule